// File: doc/BRIEF.md
# Biquinary Decade Counter with Clear and Nine-Load

This block is a four-bit decimal counter made of two separate sections: a toggle stage that divides by two (output bit A) and a three-bit stage that counts modulo five (output bits B, C, D). Each section has its own count input, and a mode selector chooses how the two sections are joined: the toggle stage feeding the modulo-five stage (plain decimal count), the modulo-five stage feeding the toggle stage (a divide-by-ten square wave on A), or no join at all (two independent counters).

All inputs arrive asynchronously and pass through a synchroniser into one system clock domain. A section advances when its count input falls from high to low. When one section feeds the other in a chained mode, the carry moves the second section in the same system clock cycle as the first. Two request pairs act as gated forcing inputs: both bits of the zero pair high clears the count, and both bits of the nine pair high loads decimal nine. While either force is active, count edges are discarded.

Top module: `biq_decade_counter`

## Requirements
- R1: After system reset the output `cntOut` = {D,C,B,A} reads 4'b0000.
- R2: With `modeSel` = 2'd0, each falling edge of `cntInA` steps `cntOut` through 0,1,...,9 and back to 0; `cntInB` has no effect in this mode.
- R3: With `modeSel` = 2'd1, each falling edge of `cntInB` advances the modulo-five stage (bits [3:1]) through 0..4; when bit D falls, bit A toggles, so A stays high for five input edges and low for five; `cntInA` has no effect.
- R4: With `modeSel` = 2'd2 or 2'd3, a falling edge of `cntInA` toggles only bit A and a falling edge of `cntInB` advances only bits [3:1] through 0..4 and back to 0.
- R5: When both bits of `zeroReq` are high, `cntOut` becomes 4'b0000; a single high bit changes nothing.
- R6: When both bits of `nineReq` are high, `cntOut` becomes 4'b1001; a single high bit changes nothing.
- R7: When both request pairs are fully asserted at once, the nine load wins and `cntOut` reads 4'b1001.
- R8: Count edges that arrive while either force is active are discarded; after release, counting resumes from the forced value.
- R9: A change on any input reaches `cntOut` on the third rising clock edge after the change with the default two-stage synchroniser; the modulo-five stage, if left at 4 or above, returns to 0 on its next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| cntInA | input | 1 | Count input of the divide-by-two stage, active on falling edge |
| cntInB | input | 1 | Count input of the modulo-five stage, active on falling edge |
| zeroReq | input | 2 | Clear request pair; acts only when both bits are high |
| nineReq | input | 2 | Nine-load request pair; acts only when both bits are high |
| modeSel | input | 2 | 0 decimal, 1 symmetric divide-by-ten, 2 or 3 independent |
| cntOut | output | 4 | Count value {D,C,B,A} |

## Verification
The hardest condition to reach from the ports is a carry between sections landing in the same cycle as the first section's step, since only the 1-to-2, 3-to-4, 5-to-6, 7-to-8 and 9-to-0 steps of decimal mode and the 4-to-0 step of symmetric mode produce one. The stimulus walks each chained mode through more than a full cycle, one edge at a time, so every carry occurs and each intermediate value is checked. Forced states are reached by holding request pairs while count pulses are applied, and then releasing them to confirm that the lost edges did not count.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef enum logic [1:0] {
    MODE_BCD       = 2'd0,
    MODE_SYM       = 2'd1,
    MODE_SPLIT     = 2'd2,
    MODE_SPLIT_ALT = 2'd3
  } cntMode_e;

  typedef struct packed {
    logic clrAll;
    logic setNine;
    logic stepTwo;
    logic stepFive;
  } stepCtl_t;

  localparam int FIVE_W   = 3;
  localparam int FIVE_TOP = 4;
  localparam int REQ_W    = 2;
  localparam int MODE_W   = 2;
endpackage

// File: rtl/bq_sync.sv
module bq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= dIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= '0;
      else       stg[i] <= stg[i-1];
    end
  end

  assign dOut = stg[STAGES-1];
endmodule

// File: rtl/bq_control.sv
module bq_control
  import bq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntA,
  input  logic              cntB,
  input  logic [REQ_W-1:0]  zeroIn,
  input  logic [REQ_W-1:0]  nineIn,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              curA,
  input  logic              curD,
  output stepCtl_t          ctl
);
  logic prevA, prevB;
  logic fallA, fallB;
  logic zeroHit, nineHit, forced;
  logic rawTwo, rawFive;
  cntMode_e mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= cntA;
      prevB <= cntB;
    end
  end

  assign fallA   = prevA & ~cntA;
  assign fallB   = prevB & ~cntB;
  assign zeroHit = &zeroIn;
  assign nineHit = &nineIn;
  assign forced  = zeroHit | nineHit;
  assign mode    = cntMode_e'(modeIn);

  always_comb begin
    rawTwo  = 1'b0;
    rawFive = 1'b0;
    unique case (mode)
      MODE_BCD: begin
        rawTwo  = fallA;
        rawFive = fallA & curA;
      end
      MODE_SYM: begin
        rawFive = fallB;
        rawTwo  = fallB & curD;
      end
      default: begin
        rawTwo  = fallA;
        rawFive = fallB;
      end
    endcase
  end

  always_comb begin
    ctl.setNine  = nineHit;
    ctl.clrAll   = zeroHit & ~nineHit;
    ctl.stepTwo  = rawTwo  & ~forced;
    ctl.stepFive = rawFive & ~forced;
  end

  AST_FORCE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrAll || ctl.setNine) |-> (!ctl.stepTwo && !ctl.stepFive)); // R8
endmodule

// File: rtl/bq_datapath.sv
module bq_datapath
  import bq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  output logic              bitA,
  output logic [FIVE_W-1:0] fiveQ
);
  localparam logic [FIVE_W-1:0] FiveMax = FIVE_W'(FIVE_TOP);

  logic [FIVE_W-1:0] fiveNext;

  always_comb begin
    if (fiveQ >= FiveMax) fiveNext = '0;
    else                  fiveNext = fiveQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitA  <= 1'b0;
      fiveQ <= '0;
    end else if (ctl.setNine) begin
      bitA  <= 1'b1;
      fiveQ <= FiveMax;
    end else if (ctl.clrAll) begin
      bitA  <= 1'b0;
      fiveQ <= '0;
    end else begin
      if (ctl.stepTwo)  bitA  <= ~bitA;
      if (ctl.stepFive) fiveQ <= fiveNext;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrAll |=> (bitA == 1'b0 && fiveQ == '0)); // R5
  AST_NINE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setNine |=> (bitA == 1'b1 && fiveQ == FiveMax)); // R6
  AST_FIVE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fiveQ <= FiveMax); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl == '0) |=> ($stable(bitA) && $stable(fiveQ))); // R8
endmodule

// File: rtl/biq_decade_counter.sv
module biq_decade_counter
  import bq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntInA,
  input  logic              cntInB,
  input  logic [REQ_W-1:0]  zeroReq,
  input  logic [REQ_W-1:0]  nineReq,
  input  logic [MODE_W-1:0] modeSel,
  output logic [3:0]        cntOut
);
  localparam int SYNC_W = 2 + 2 * REQ_W + MODE_W;

  logic [SYNC_W-1:0] rawIn, syncIn;
  logic              sA, sB;
  logic [REQ_W-1:0]  sZero, sNine;
  logic [MODE_W-1:0] sMode;
  logic              bitA;
  logic [FIVE_W-1:0] fiveQ;
  stepCtl_t          ctl;

  assign rawIn = {modeSel, nineReq, zeroReq, cntInB, cntInA};
  assign {sMode, sNine, sZero, sB, sA} = syncIn;

  bq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(rawIn), .dOut(syncIn)
  );

  bq_control u_ctrl (
    .clk(clk), .rstN(rstN), .cntA(sA), .cntB(sB),
    .zeroIn(sZero), .nineIn(sNine), .modeIn(sMode),
    .curA(bitA), .curD(fiveQ[FIVE_W-1]), .ctl(ctl)
  );

  bq_datapath u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitA(bitA), .fiveQ(fiveQ)
  );

  assign cntOut = {fiveQ, bitA};

  AST_BCD_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cntOut[0]) && $past(sMode) == MODE_BCD && !$past(ctl.clrAll))
      |-> (cntOut[3:1] != $past(cntOut[3:1]))); // R2
endmodule

// File: tb/test_biq_decade_counter.sv
module test_biq_decade_counter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntInA = 1'b1;
  logic       cntInB = 1'b1;
  logic [1:0] zeroReq = 2'b00;
  logic [1:0] nineReq = 2'b00;
  logic [1:0] modeSel = 2'd0;
  logic [3:0] cntOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  biq_decade_counter i_biq_decade_counter (
    .clk(clk), .rstN(rstN), .cntInA(cntInA), .cntInB(cntInB),
    .zeroReq(zeroReq), .nineReq(nineReq), .modeSel(modeSel), .cntOut(cntOut)
  );

  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if (cntOut !== exp) begin
      fails++;
      $display("FAIL %s: cntOut=%b expected=%b", tag, cntOut, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseA();
    cntInA = 1'b0; settle();
    cntInA = 1'b1; settle();
  endtask

  task automatic pulseB();
    cntInB = 1'b0; settle();
    cntInB = 1'b1; settle();
  endtask

  task automatic clearNow();
    zeroReq = 2'b11; settle();
    zeroReq = 2'b00; settle();
  endtask

  task automatic t_reset();
    chk("R1 reset value", 4'b0000);
  endtask

  task automatic t_bcd();
    modeSel = 2'd0; clearNow();
    for (int k = 1; k <= 12; k++) begin
      pulseA();
      chk("R2 decimal step", 4'(k % 10));
    end
    pulseB();
    chk("R2 cntInB ignored", 4'd2);
  endtask

  task automatic t_sym();
    int highs = 0;
    modeSel = 2'd1; clearNow();
    for (int k = 1; k <= 20; k++) begin
      pulseB();
      chk("R3 symmetric step", {3'(k % 5), 1'((k / 5) % 2)});
      if (cntOut[0]) highs++;
    end
    checks++;
    if (highs != 10) begin
      fails++;
      $display("FAIL R3 duty: high=%0d expected=10", highs);
    end
    pulseB();
    pulseA();
    chk("R3 cntInA ignored", 4'b0010);
  endtask

  task automatic t_split();
    modeSel = 2'd2; clearNow();
    for (int k = 1; k <= 6; k++) begin
      pulseB();
      chk("R4 five stage alone", {3'(k % 5), 1'b0});
    end
    pulseA();
    chk("R4 toggle alone", 4'b0011);
    modeSel = 2'd3; settle();
    pulseA();
    chk("R4 toggle alone mode3", 4'b0010);
    pulseB();
    chk("R4 five stage mode3", 4'b0100);
  endtask

  task automatic t_force();
    modeSel = 2'd0; clearNow();
    pulseA(); pulseA(); pulseA();
    zeroReq = 2'b01; settle();
    chk("R5 single zero bit", 4'd3);
    zeroReq = 2'b10; settle();
    chk("R5 single zero bit", 4'd3);
    zeroReq = 2'b11; settle();
    chk("R5 clear", 4'd0);
    zeroReq = 2'b00; settle();
    nineReq = 2'b10; settle();
    chk("R6 single nine bit", 4'd0);
    nineReq = 2'b11; settle();
    chk("R6 nine load", 4'b1001);
    nineReq = 2'b00; settle();
    pulseA();
    chk("R9 wrap after nine", 4'd0);
    zeroReq = 2'b11; nineReq = 2'b11; settle();
    chk("R7 nine wins", 4'b1001);
    zeroReq = 2'b00; nineReq = 2'b00; settle();
  endtask

  task automatic t_block();
    modeSel = 2'd0; clearNow();
    zeroReq = 2'b11; settle();
    pulseA(); pulseA(); pulseA();
    chk("R8 blocked under clear", 4'd0);
    zeroReq = 2'b00; settle();
    chk("R8 after clear release", 4'd0);
    pulseA();
    chk("R8 resumes", 4'd1);
    nineReq = 2'b11; settle();
    pulseA(); pulseA();
    chk("R8 blocked under nine", 4'b1001);
    nineReq = 2'b00; settle();
    chk("R8 after nine release", 4'b1001);
  endtask

  task automatic t_latency();
    modeSel = 2'd0; clearNow();
    cntInA = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 not yet", 4'd0);
    @(posedge clk); #1;
    chk("R9 third edge", 4'd1);
    cntInA = 1'b1; settle();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    settle();
    t_reset();
    t_bcd();
    t_sym();
    t_split();
    t_force();
    t_block();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule